// File: doc/BRIEF.md
# Shift-Only Fixed-Point Dense Layer

This block evaluates one fully connected layer of a small fixed-point neural receiver. Every weight is zero or a signed power of two, so each product reduces to a sign-extended arithmetic shift followed by an optional negation. No multiplier is used. Weight codes and biases are synthesis-time parameters: the shift amounts are wired in and no weight memory exists. The same module serves all three layers of the receiver. Parameters select the input count, the output count, whether a bias is added and whether ReLU is applied. The last layer runs with neither, and its raw pre-activations are its outputs.

Data is signed two's complement with 14 bits: one sign bit, 5 integer bits and 8 fractional bits. The implicit scale is 2^-8. A host fills the input register bank through a write port and pulses `start`. The block then works through one input-weight term per clock, one output neuron after another. Each finished neuron is written to the output bank. A one-cycle `done` marks the end of the layer. The results are read back through a combinational read port.

Top module: `shift_dense_layer`

## Requirements
- R1: After reset, `busy` and `done` are low and every output bank entry reads 0.
- R2: A weight code has 6 bits. Bit 5 set means the weight is zero. Bit 4 set means the shifted input is negated. Bit 3 set selects a left shift, clear selects a right shift. Bits 2:0 hold the shift amount 0..7. The term is therefore the input times ±2^k, with -7 <= k <= 7. The code for output n and input i sits at bit offset (n*N_IN+i)*6 of `WCODES`.
- R3: Right shifts are arithmetic and round toward minus infinity. For example, -1 shifted right by 1 gives -1, and -3 shifted right by 2 gives -1.
- R4: When `USE_BIAS` is 1, the 14-bit bias of output n, taken from bits n*14 of `BIASES`, is added to that output's sum. When `USE_BIAS` is 0, no bias is added.
- R5: When `USE_RELU` is 1, a negative sum is written as 0. When `USE_RELU` is 0, negative sums keep their value.
- R6: The sum is accumulated exactly, without wrap-around. The written result is clamped to the range -8192..8191.
- R7: A `start` pulse taken while idle makes `busy` high from the next cycle. `done` is high for exactly one cycle, N_IN*N_OUT cycles after the edge that took `start`. All outputs are already in the bank in that cycle, and `busy` is low.
- R8: A `start` pulse while `busy` is high is ignored and does not shorten or restart the layer.
- R9: An input bank write while idle stores the data at the addressed entry. A write while `busy` is high is dropped.
- R10: An output whose weights are all zero yields its bias, after ReLU when ReLU is enabled, or 0 when no bias is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wr_en | input | 1 | Input bank write enable |
| in_wr_addr | input | IN_AW | Input bank entry to write |
| in_wr_data | input | DATA_W | Fixed-point input value |
| start | input | 1 | Begin evaluating the layer |
| busy | output | 1 | Layer evaluation in progress |
| done | output | 1 | One-cycle pulse after the last output is written |
| out_rd_addr | input | OUT_AW | Output bank entry to read |
| out_rd_data | output | DATA_W | Output bank value at `out_rd_addr` |

## Verification
On every cycle, the embedded assertions check the following. `done` is a single-cycle pulse that never coincides with `busy`. `busy` only rises after a `start`. A stray `start` during a run never stops the run. The input bank is frozen while the layer runs. With ReLU enabled, no negative value reaches the output bank. A saturating sum writes exactly the clamp value. The numeric results depend on the weight pattern and the input values, so only the bench scenarios can show them. These results cover the shift direction and sign decoding, rounding toward minus infinity, bias handling, all-zero weight rows and saturation at both ends. The scenarios also show the exact latency, that a dropped input write really did not land, and that the linear configuration keeps its negative results.

// File: rtl/shdl_pkg.sv
package shdl_pkg;
    localparam int CODE_W    = 6;
    localparam int EXP_W     = 3;
    localparam int ZERO_BIT  = 5;
    localparam int NEG_BIT   = 4;
    localparam int LEFT_BIT  = 3;
    localparam int MAX_SHIFT = (1 << EXP_W) - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/shdl_shift_term.sv
module shdl_shift_term
    import shdl_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int ACC_W  = 25
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [ACC_W-1:0]  term_o
);
    logic signed [ACC_W-1:0] x_wide;
    logic signed [ACC_W-1:0] shifted;
    logic [EXP_W-1:0]        amount;

    always_comb begin
        x_wide  = {{(ACC_W-DATA_W){x_i[DATA_W-1]}}, x_i};
        amount  = code_i[EXP_W-1:0];
        if (code_i[LEFT_BIT]) shifted = x_wide <<< amount;
        else                  shifted = x_wide >>> amount;
        if (code_i[ZERO_BIT])     term_o = '0;
        else if (code_i[NEG_BIT]) term_o = -shifted;
        else                      term_o = shifted;
    end
endmodule

// File: rtl/shdl_bank.sv
module shdl_bank #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 14,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && !lock_i && (int'(wr_addr_i) < DEPTH))
            mem_d[wr_addr_i] = wr_data_i;
        rd_data_o = (int'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R9: a locked bank keeps its contents through a write attempt
    assert_locked_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && wr_en_i) |=> $stable(mem_q));
endmodule

// File: rtl/shdl_post.sv
module shdl_post #(
    parameter int DATA_W   = 14,
    parameter int ACC_W    = 25,
    parameter bit USE_RELU = 1'b1
) (
    input  logic [ACC_W-1:0]  acc_i,
    output logic [DATA_W-1:0] res_o
);
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (DATA_W-1));

    logic signed [ACC_W-1:0] act;

    generate
        if (USE_RELU) begin : g_relu
            always_comb act = acc_i[ACC_W-1] ? '0 : $signed(acc_i);
        end else begin : g_linear
            always_comb act = $signed(acc_i);
        end
    endgenerate

    always_comb begin
        if (act > MAX_V)      res_o = MAX_V[DATA_W-1:0];
        else if (act < MIN_V) res_o = MIN_V[DATA_W-1:0];
        else                  res_o = act[DATA_W-1:0];
    end
endmodule

// File: rtl/shift_dense_layer.sv
module shift_dense_layer
    import shdl_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int N_IN     = 8,
    parameter int N_OUT    = 4,
    parameter bit USE_BIAS = 1'b1,
    parameter bit USE_RELU = 1'b1,
    parameter logic [N_OUT*N_IN*CODE_W-1:0] WCODES = '0,
    parameter logic [N_OUT*DATA_W-1:0]      BIASES = '0,
    localparam int IN_AW  = (N_IN  > 1) ? $clog2(N_IN)  : 1,
    localparam int OUT_AW = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_wr_en,
    input  logic [IN_AW-1:0]  in_wr_addr,
    input  logic [DATA_W-1:0] in_wr_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [OUT_AW-1:0] out_rd_addr,
    output logic [DATA_W-1:0] out_rd_data
);
    localparam int ACC_W = DATA_W + MAX_SHIFT + IN_AW + 1;
    localparam logic [IN_AW-1:0]  LAST_IN  = IN_AW'(N_IN - 1);
    localparam logic [OUT_AW-1:0] LAST_OUT = OUT_AW'(N_OUT - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (DATA_W-1)) - 1);

    typedef struct packed {
        seq_state_e              st;
        logic [OUT_AW-1:0]       nrn;
        logic [IN_AW-1:0]        idx;
        logic signed [ACC_W-1:0] acc;
        logic                    done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [DATA_W-1:0] x_cur;
    logic [CODE_W-1:0] code_cur;
    logic [ACC_W-1:0]  term;
    logic signed [ACC_W-1:0] acc_sum;
    logic [DATA_W-1:0] result;
    logic              ob_wr;

    function automatic logic signed [ACC_W-1:0] bias_ext(input int n);
        logic [DATA_W-1:0] b;
        if (!USE_BIAS) return '0;
        b = BIASES[n*DATA_W +: DATA_W];
        return {{(ACC_W-DATA_W){b[DATA_W-1]}}, b};
    endfunction

    shdl_bank #(.DEPTH(N_IN), .DATA_W(DATA_W), .AW(IN_AW)) u_in_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (busy),
        .wr_en_i  (in_wr_en),
        .wr_addr_i(in_wr_addr),
        .wr_data_i(in_wr_data),
        .rd_addr_i(seq_q.idx),
        .rd_data_o(x_cur)
    );

    always_comb code_cur = WCODES[(int'(seq_q.nrn)*N_IN + int'(seq_q.idx))*CODE_W +: CODE_W];

    shdl_shift_term #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_term (
        .x_i   (x_cur),
        .code_i(code_cur),
        .term_o(term)
    );

    always_comb acc_sum = seq_q.acc + $signed(term);

    shdl_post #(.DATA_W(DATA_W), .ACC_W(ACC_W), .USE_RELU(USE_RELU)) u_post (
        .acc_i(acc_sum),
        .res_o(result)
    );

    shdl_bank #(.DEPTH(N_OUT), .DATA_W(DATA_W), .AW(OUT_AW)) u_out_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (1'b0),
        .wr_en_i  (ob_wr),
        .wr_addr_i(seq_q.nrn),
        .wr_data_i(result),
        .rd_addr_i(out_rd_addr),
        .rd_data_o(out_rd_data)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ob_wr      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st  = ST_RUN;
                    seq_d.nrn = '0;
                    seq_d.idx = '0;
                    seq_d.acc = bias_ext(0);
                end
            end
            default: begin
                if (seq_q.idx == LAST_IN) begin
                    ob_wr = 1'b1;
                    if (seq_q.nrn == LAST_OUT) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.nrn = seq_q.nrn + 1'b1;
                        seq_d.idx = '0;
                        seq_d.acc = bias_ext(int'(seq_q.nrn) + 1);
                    end
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.acc = acc_sum;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, nrn: '0, idx: '0, acc: '0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.st == ST_RUN);
    assign done = seq_q.done;

    // R7: done lasts one cycle and never overlaps a run
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8: a start during a run does not end it early
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !ob_wr) |=> busy);
    // R6: an over-range sum writes exactly the upper clamp value
    assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_wr && (acc_sum > SAT_HI)) |-> (result == SAT_HI[DATA_W-1:0]));

    generate
        if (USE_RELU) begin : g_relu_chk
            // R5: no negative value reaches the output bank
            assert_relu_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ob_wr |-> !result[DATA_W-1]);
        end
    endgenerate
endmodule

// File: tb/test_shift_dense_layer.sv
module test_shift_dense_layer;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 14;
    localparam int NI    = 8;
    localparam int NO    = 6;
    localparam int IAW   = 3;
    localparam int OAW   = 3;
    localparam int CW    = 6;

    function automatic logic [CW-1:0] gen_code(input int n, input int i);
        case (n)
            0: return 6'b100000;
            1: return {3'b001, 3'd7};
            2: return {3'b011, 3'd7};
            3: return {2'b00, i[0], 1'b0, 3'(i)};
            4: return {2'b00, ((i % 3) == 0), 1'b1, 3'(i % 4)};
            default: return (i == 2) ? 6'b100000 : {3'b010, 3'd1};
        endcase
    endfunction

    function automatic int gen_bias(input int n);
        return (n == 0) ? 300 : n * 97 - 260;
    endfunction

    function automatic logic [NO*NI*CW-1:0] mk_codes();
        logic [NO*NI*CW-1:0] v = '0;
        for (int n = 0; n < NO; n++)
            for (int i = 0; i < NI; i++)
                v[(n*NI+i)*CW +: CW] = gen_code(n, i);
        return v;
    endfunction

    function automatic logic [NO*DW-1:0] mk_biases();
        logic [NO*DW-1:0] v = '0;
        for (int n = 0; n < NO; n++) v[n*DW +: DW] = DW'(gen_bias(n));
        return v;
    endfunction

    localparam logic [NO*NI*CW-1:0] CODES = mk_codes();
    localparam logic [NO*DW-1:0]    BIAS  = mk_biases();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_wr_en = 1'b0;
    logic [IAW-1:0] in_wr_addr = '0;
    logic [DW-1:0]  in_wr_data = '0;
    logic start = 1'b0;
    logic [OAW-1:0] out_rd_addr = '0;
    logic busy_a, done_a, busy_b, done_b;
    logic [DW-1:0] rd_a, rd_b;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int xin [NI];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_dense_layer #(.DATA_W(DW), .N_IN(NI), .N_OUT(NO), .USE_BIAS(1'b1), .USE_RELU(1'b1),
        .WCODES(CODES), .BIASES(BIAS)) i_shift_dense_layer (
        .clk(clk), .rst_n(rst_n), .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr),
        .in_wr_data(in_wr_data), .start(start), .busy(busy_a), .done(done_a),
        .out_rd_addr(out_rd_addr), .out_rd_data(rd_a));

    shift_dense_layer #(.DATA_W(DW), .N_IN(NI), .N_OUT(NO), .USE_BIAS(1'b0), .USE_RELU(1'b0),
        .WCODES(CODES), .BIASES(BIAS)) i_shift_dense_layer_lin (
        .clk(clk), .rst_n(rst_n), .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr),
        .in_wr_data(in_wr_data), .start(start), .busy(busy_b), .done(done_b),
        .out_rd_addr(out_rd_addr), .out_rd_data(rd_b));

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference per R2..R6, R10 with wide integers
    function automatic longint ref_out(input int n, input bit bias_on, input bit relu_on);
        longint s = bias_on ? longint'(gen_bias(n)) : 0;
        for (int i = 0; i < NI; i++) begin
            logic [CW-1:0] c = gen_code(n, i);
            longint v = longint'(xin[i]);
            if (!c[5]) begin
                if (c[3]) v = v <<< c[2:0];
                else      v = v >>> c[2:0];
                if (c[4]) v = -v;
                s += v;
            end
        end
        if (relu_on && s < 0) s = 0;
        if (s > 8191)  s = 8191;
        if (s < -8192) s = -8192;
        return s;
    endfunction

    task automatic load_inputs(input int v0, input int v1, input int v2, input int v3,
                               input int v4, input int v5, input int v6, input int v7);
        int vals [NI] = '{v0, v1, v2, v3, v4, v5, v6, v7};
        for (int i = 0; i < NI; i++) begin
            @(negedge clk);
            in_wr_en = 1'b1; in_wr_addr = IAW'(i); in_wr_data = DW'(vals[i]);
            xin[i] = vals[i];
        end
        @(negedge clk);
        in_wr_en = 1'b0;
    endtask

    // R7 latency and pulse shape; optional disturbances for R8 and R9
    task automatic run_layer(input bit poke_start, input bit poke_write);
        int cycles = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R7 busy after start", busy_a, 1);
        while (!done_a && cycles < 200) begin
            @(negedge clk);
            cycles++;
            if (cycles == 3 && poke_start) start = 1'b1;
            if (cycles == 4) start = 1'b0;
            if (cycles == 5 && poke_write) begin
                in_wr_en = 1'b1; in_wr_addr = '0; in_wr_data = DW'(-4000);
            end
            if (cycles == 6) in_wr_en = 1'b0;
        end
        check("R7 done latency", cycles, NI*NO);
        check("R7 lin done aligned", done_b, 1);
        check("R7 idle at done", busy_a, 0);
        @(negedge clk);
        check("R7 done one cycle", done_a, 0);
    endtask

    task automatic check_outputs(input string scen);
        string tag;
        for (int n = 0; n < NO; n++) begin
            out_rd_addr = OAW'(n);
            #1;
            tag = (n == 0) ? "R10" : (n <= 2) ? "R6" : (n == 3) ? "R3" : "R2";
            check({scen, " ", tag, " R4 R5 relu+bias"}, longint'($signed(rd_a)), ref_out(n, 1'b1, 1'b1));
            check({scen, " ", tag, " R4 R5 linear"},    longint'($signed(rd_b)), ref_out(n, 1'b0, 1'b0));
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy_a, 0);
        check("R1 done", done_a, 0);
        for (int n = 0; n < NO; n++) begin
            out_rd_addr = OAW'(n); #1;
            check("R1 out bank", rd_a, 0);
        end
    endtask

    task automatic t_mixed();
        load_inputs(256, -256, 1000, -37, 5, -3, 700, -812);
        run_layer(1'b0, 1'b0);
        check_outputs("mixed");
    endtask

    task automatic t_saturate();
        load_inputs(8191, 8191, 8191, 8191, 8191, 8191, 8191, 8191);
        run_layer(1'b0, 1'b0);
        check_outputs("sat max R6");
        load_inputs(-8192, -8192, -8192, -8192, -8192, -8192, -8192, -8192);
        run_layer(1'b0, 1'b0);
        check_outputs("sat min R6");
    endtask

    task automatic t_truncate();
        load_inputs(-1, -3, -5, -7, 1, 3, 5, -255);
        run_layer(1'b0, 1'b0);
        check_outputs("trunc R3");
    endtask

    task automatic t_zero_inputs();
        load_inputs(0, 0, 0, 0, 0, 0, 0, 0);
        run_layer(1'b0, 1'b0);
        check_outputs("zero in R10");
    endtask

    task automatic t_busy_disturb();
        load_inputs(40, -90, 17, 2048, -2, 999, -600, 123);
        run_layer(1'b1, 1'b1);
        check_outputs("R8 R9 during run");
        run_layer(1'b0, 1'b0);
        check_outputs("R9 dropped write rerun");
    endtask

    initial begin : watchdog
        wait (cyc > 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_saturate();
        t_truncate();
        t_zero_inputs();
        t_busy_disturb();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule